// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a multi-drop line. Each frame is a start bit (0), eight data bits sent least significant bit first, one multiprocessor bit, and one stop bit (1). The line idles at 1. The multiprocessor bit tells an address frame (bit = 1) from a data frame (bit = 0). A station that is not addressed can set the address-filter flag `mp_en`. While the flag is set, the receiver drops every data frame without a trace. The next address frame is then delivered, and the flag clears itself in the same cycle. After that, frames are delivered as in plain asynchronous mode until software sets the flag again.

A baud enable `baud_tick` runs at sixteen times the bit rate. The line passes through a two-stage synchronizer. A falling edge moves the frame state machine from IDLE to START. START confirms the start bit half a bit later and goes to DATA, or back to IDLE on a false start. DATA takes one sample at each bit centre. MPB captures the multiprocessor bit. STOP samples the stop bit, emits a completion pulse and returns to IDLE.

The delivery unit sorts each completed frame into one of five actions:
- ACT_NONE: no frame completed.
- ACT_FRAMING: bad stop bit.
- ACT_SKIP: a data frame that the filter drops.
- ACT_OVERRUN: the receive buffer is still full.
- ACT_LOAD: the frame is delivered.

Top module: `mp_uart_rx`

## Requirements
- R1: While reset is asserted, `rx_data` is 0 and `rx_full`, `rx_mpb`, `rx_irq`, `mp_en`, `frm_err` and `ovr_err` are all 0.
- R2: While `mp_en` is 0, a frame with a valid stop bit does four things, if `rx_full` is 0: it loads its data into `rx_data` (first serial bit into bit 0), sets `rx_full`, copies its multiprocessor bit into `rx_mpb`, and raises `rx_irq` for exactly one clock. With `baud_tick` high every cycle, these updates are visible 172 clock cycles after the cycle in which the line falls for the start bit.
- R3: A one-cycle pulse on `mp_set` makes `mp_en` read 1 from the next cycle. If an address frame is delivered in that same cycle, the pulse wins and the flag stays 1.
- R4: While `mp_en` is 1, a frame whose multiprocessor bit is 0 leaves `rx_data`, `rx_full`, `rx_mpb` and `mp_en` unchanged and raises no `rx_irq`.
- R5: While `mp_en` is 1, a frame whose multiprocessor bit is 1 is delivered as in R2, and `mp_en` reads 0 in the same cycle that `rx_irq` is high.
- R6: Once `mp_en` has been cleared by an address frame, later frames with a multiprocessor bit of 0 are delivered as in R2.
- R7: A one-cycle pulse on `rd_clr` makes `rx_full`, `frm_err` and `ovr_err` read 0 from the next cycle.
- R8: A frame whose stop bit is sampled as 0 sets `frm_err`. It changes neither `rx_data` nor `rx_full`, and raises no `rx_irq`.
- R9: A frame that would be delivered while `rx_full` is 1 sets `ovr_err`. It leaves `rx_data`, `rx_mpb` and `mp_en` unchanged and raises no `rx_irq`.
- R10: A low pulse on the line shorter than half a bit time is not taken as a start bit, and no output changes.
- R11: Bit timing counts `baud_tick` pulses, not clock cycles. A frame sent at a rate matching a tick every second cycle is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Enable at sixteen times the bit rate |
| mp_set | input | 1 | Strobe that sets the address-filter flag |
| rd_clr | input | 1 | Strobe that clears the full and error flags after a read |
| rx_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Receive data register holds unread data |
| rx_mpb | output | 1 | Multiprocessor bit of the last delivered frame |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| mp_en | output | 1 | Address-filter flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |

## Verification
The hardest situation to reach is the self-clearing filter working in sequence with the software re-arm. To reach it, the stimulus sets the filter and sends data frames that must vanish. It then sends an address frame that must get through, clears the buffer, re-arms the filter as a station that is not addressed, and checks that the next data frame vanishes again. Overrun needs the address frame to land while the buffer is still full, so the stimulus leaves the buffer unread on purpose. A cycle-exact reference model checks every output on every clock, so a delivery one cycle early or late is caught.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    // Frame reception states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } rx_state_t;

    // Action taken on a completed frame
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_FRAMING,
        ACT_SKIP,
        ACT_OVERRUN,
        ACT_LOAD
    } rx_act_t;

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic              done,
    output logic [DATA_W-1:0] shreg,
    output logic              mpb,
    output logic              stop_ok
);

    localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_t        state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             at_end;
    logic             at_half;

    assign at_end  = tick && (cnt == CNT_END);
    assign at_half = tick && (cnt == CNT_HALF);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state decisions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (tick && !line) state_n = ST_START;
            ST_START: if (at_half)       state_n = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_end && idx == IDX_LAST) state_n = ST_MPB;
            ST_MPB:   if (at_end)        state_n = ST_STOP;
            ST_STOP:  if (at_end)        state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    // Counters, sampled bits and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            mpb     <= 1'b0;
            stop_ok <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_n != state || state == ST_IDLE) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= (cnt == CNT_END) ? '0 : cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                end
                ST_START: begin
                    idx <= '0;
                end
                ST_DATA: begin
                    if (at_end) begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                        idx   <= idx + 1'b1;
                    end
                end
                ST_MPB: begin
                    if (at_end) mpb <= line;
                end
                ST_STOP: begin
                    if (at_end) begin
                        stop_ok <= line;
                        done    <= 1'b1;
                    end
                end
                default: begin
                    idx <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mpr_accept.sv
module mpr_accept
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_mpb,
    input  logic              frame_stop_ok,
    input  logic              mp_set,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_mpb,
    output logic              rx_irq,
    output logic              mp_en,
    output logic              frm_err,
    output logic              ovr_err
);

    rx_act_t act;

    // Sort the completed frame into one action
    always_comb begin
        act = ACT_NONE;
        if (done) begin
            if (!frame_stop_ok)              act = ACT_FRAMING;
            else if (mp_en && !frame_mpb)    act = ACT_SKIP;
            else if (rx_full && !rd_clr)     act = ACT_OVERRUN;
            else                             act = ACT_LOAD;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_mpb  <= 1'b0;
            rx_irq  <= 1'b0;
            mp_en   <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (rd_clr) begin
                rx_full <= 1'b0;
                frm_err <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (mp_set) mp_en <= 1'b1;
            unique case (act)
                ACT_NONE:    ;
                ACT_SKIP:    ;
                ACT_FRAMING: frm_err <= 1'b1;
                ACT_OVERRUN: ovr_err <= 1'b1;
                ACT_LOAD: begin
                    rx_data <= frame_data;
                    rx_full <= 1'b1;
                    rx_mpb  <= frame_mpb;
                    rx_irq  <= 1'b1;
                    if (frame_mpb && !mp_set) mp_en <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              mp_set,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_mpb,
    output logic              rx_irq,
    output logic              mp_en,
    output logic              frm_err,
    output logic              ovr_err
);

    logic              line_s;
    logic              f_done;
    logic [DATA_W-1:0] f_data;
    logic              f_mpb;
    logic              f_stop_ok;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    mpr_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .line   (line_s),
        .done   (f_done),
        .shreg  (f_data),
        .mpb    (f_mpb),
        .stop_ok(f_stop_ok)
    );

    mpr_accept #(.DATA_W(DATA_W)) u_accept (
        .clk          (clk),
        .rst_n        (rst_n),
        .done         (f_done),
        .frame_data   (f_data),
        .frame_mpb    (f_mpb),
        .frame_stop_ok(f_stop_ok),
        .mp_set       (mp_set),
        .rd_clr       (rd_clr),
        .rx_data      (rx_data),
        .rx_full      (rx_full),
        .rx_mpb       (rx_mpb),
        .rx_irq       (rx_irq),
        .mp_en        (mp_en),
        .frm_err      (frm_err),
        .ovr_err      (ovr_err)
    );

endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_set,
    input logic              rd_clr,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rx_mpb,
    input logic              rx_irq,
    input logic              mp_en,
    input logic              frm_err
);

    // R2: interrupt lasts one cycle
    a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R3: set strobe always takes effect
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mp_set) |-> mp_en);

    // R4: with the filter on, only address frames are delivered
    a_r4_filter_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && $past(mp_en)) |-> rx_mpb);

    // R5: delivered address frame clears the filter
    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && rx_mpb && !$past(mp_set)) |-> !mp_en);

    // R7: clear strobe empties the buffer unless a frame lands with it
    a_r7_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_clr) && !rx_irq) |-> !rx_full);

    // R8: framing error delivers nothing
    a_r8_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err) |-> (!rx_irq && $stable(rx_data)));

    // R9: full buffer is not overwritten
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_full) && !$past(rd_clr)) |-> (!rx_irq && $stable(rx_data)));

endmodule

bind mp_uart_rx mpr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mp_set (mp_set),
    .rd_clr (rd_clr),
    .rx_data(rx_data),
    .rx_full(rx_full),
    .rx_mpb (rx_mpb),
    .rx_irq (rx_irq),
    .mp_en  (mp_en),
    .frm_err(frm_err)
);

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;

    localparam int LAT = 172;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       slow = 1'b0;
    logic       baud_tick;
    logic       mp_set = 1'b0;
    logic       rd_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_mpb, rx_irq, mp_en, frm_err, ovr_err;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_en = 1'b1;
    bit    finished = 1'b0;
    string phase = "R1";

    // reference model state
    logic [7:0] e_data = 8'h00;
    logic e_full = 0, e_mpb = 0, e_irq = 0, e_mpe = 0, e_fe = 0, e_oe = 0;

    int         fq_due[$];
    logic [7:0] fq_dat[$];
    logic       fq_mpb[$];
    logic       fq_stop[$];
    int         sq_due[$];
    int         sq_kind[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign baud_tick = slow ? ~cyc[0] : 1'b1;

    mp_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .mp_set(mp_set), .rd_clr(rd_clr), .rx_data(rx_data),
        .rx_full(rx_full), .rx_mpb(rx_mpb), .rx_irq(rx_irq),
        .mp_en(mp_en), .frm_err(frm_err), .ovr_err(ovr_err)
    );

    task automatic chk(input string sig, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", phase, sig, act, exp, cyc);
        end
    endtask

    function automatic void model_frame(input logic [7:0] d, input logic m, input logic s);
        if (!s)                 e_fe = 1'b1;
        else if (e_mpe && !m)   ;
        else if (e_full)        e_oe = 1'b1;
        else begin
            e_data = d; e_full = 1'b1; e_mpb = m; e_irq = 1'b1;
            if (m) e_mpe = 1'b0;
        end
    endfunction

    // Model update and comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            e_irq = 1'b0;
            while (sq_due.size() > 0 && sq_due[0] == cyc) begin
                if (sq_kind[0] == 0) e_mpe = 1'b1;
                else begin e_full = 1'b0; e_fe = 1'b0; e_oe = 1'b0; end
                void'(sq_due.pop_front()); void'(sq_kind.pop_front());
            end
            while (fq_due.size() > 0 && fq_due[0] == cyc) begin
                model_frame(fq_dat[0], fq_mpb[0], fq_stop[0]);
                void'(fq_due.pop_front()); void'(fq_dat.pop_front());
                void'(fq_mpb.pop_front()); void'(fq_stop.pop_front());
            end
            if (cmp_en) begin
                chk("rx_data", 32'(rx_data), 32'(e_data));
                chk("rx_full", 32'(rx_full), 32'(e_full));
                chk("rx_mpb",  32'(rx_mpb),  32'(e_mpb));
                chk("rx_irq",  32'(rx_irq),  32'(e_irq));
                chk("mp_en",   32'(mp_en),   32'(e_mpe));
                chk("frm_err", 32'(frm_err), 32'(e_fe));
                chk("ovr_err", 32'(ovr_err), 32'(e_oe));
            end
        end
    end

    task automatic pulse_set();
        @(negedge clk);
        mp_set = 1'b1;
        sq_due.push_back(cyc + 1); sq_kind.push_back(0);
        @(negedge clk);
        mp_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        rd_clr = 1'b1;
        sq_due.push_back(cyc + 1); sq_kind.push_back(1);
        @(negedge clk);
        rd_clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic m, input logic s,
                        input int bl, input bit track);
        @(negedge clk);
        if (track) begin
            fq_due.push_back(cyc + LAT); fq_dat.push_back(d);
            fq_mpb.push_back(m); fq_stop.push_back(s);
        end
        rxd = 1'b0;
        repeat (bl) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bl) @(negedge clk);
        end
        rxd = m;
        repeat (bl) @(negedge clk);
        rxd = s;
        repeat (bl) @(negedge clk);
        rxd = 1'b1;
        repeat (bl + 8) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("rx_data", 32'(rx_data), 0);
        chk("rx_full", 32'(rx_full), 0);
        chk("rx_mpb",  32'(rx_mpb),  0);
        chk("rx_irq",  32'(rx_irq),  0);
        chk("mp_en",   32'(mp_en),   0);
        chk("frm_err", 32'(frm_err), 0);
        chk("ovr_err", 32'(ovr_err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        phase = "R2";
        send(8'hA5, 1'b0, 1'b1, 16, 1'b1);
        pulse_clr();
        send(8'h3C, 1'b1, 1'b1, 16, 1'b1);
        pulse_clr();

        phase = "R3";
        pulse_set();
        phase = "R4";
        send(8'h11, 1'b0, 1'b1, 16, 1'b1);
        send(8'h22, 1'b0, 1'b1, 16, 1'b1);
        phase = "R5";
        send(8'h07, 1'b1, 1'b1, 16, 1'b1);
        pulse_clr();
        phase = "R6";
        send(8'h55, 1'b0, 1'b1, 16, 1'b1);
        pulse_clr();

        // station not addressed: re-arm and drop the following data
        phase = "R3";
        pulse_set();
        phase = "R5";
        send(8'h09, 1'b1, 1'b1, 16, 1'b1);
        pulse_clr();
        phase = "R4";
        pulse_set();
        send(8'hC3, 1'b0, 1'b1, 16, 1'b1);

        phase = "R8";
        send(8'hF0, 1'b1, 1'b0, 16, 1'b1);
        phase = "R7";
        pulse_clr();

        phase = "R9";
        send(8'h81, 1'b1, 1'b1, 16, 1'b1);
        send(8'h66, 1'b0, 1'b1, 16, 1'b1);
        send(8'h99, 1'b1, 1'b1, 16, 1'b1);
        phase = "R7";
        pulse_clr();

        phase = "R10";
        @(negedge clk);
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (60) @(negedge clk);

        phase = "R11";
        cmp_en = 1'b0;
        slow = 1'b1;
        send(8'h4E, 1'b0, 1'b1, 32, 1'b0);
        slow = 1'b0;
        @(negedge clk);
        fq_due.push_back(cyc + 1); fq_dat.push_back(8'h4E);
        fq_mpb.push_back(1'b0); fq_stop.push_back(1'b1);
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
        repeat (4) @(negedge clk);
        pulse_clr();
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule